// File: doc/BRIEF.md
# Multicycle Control Sequencer

This block is the control state machine of a 16-bit multicycle processor core that fetches instructions and data through one shared memory port. It receives a decoded instruction class and an extension bit from the instruction register, a live compare result from the ALU, the interrupt-enable status flag and an interrupt request line. In every cycle it drives the datapath strobes: the memory address source, memory read and write, the ALU operation, both ALU operand sources, the PC source, PC write, register write, write-back source, and the strobes that save the interrupt return address and set or clear the interrupt-enable flag.

Each instruction begins with a fetch cycle and a decode cycle. A set extension bit adds one cycle that fetches a second word (an immediate or a displacement) before the instruction's own work. Every instruction ends in an end-check cycle. If interrupts are enabled and a request is pending, that cycle is followed by an entry cycle that redirects the PC to the service routine. A return-from-interrupt instruction reloads the PC from the saved return address and enables interrupts again.

The state is held in a 4-bit register. All sixteen codes are in use. The datapath, ALU, register file and memories sit outside the block.

Top module: `seqCtrl`

## Requirements
- R1: While rstN is low, every output strobe is 0, including memRead and pcWrite. The first cycle after rstN rises is a fetch cycle.
- R2: A fetch cycle drives memRead=1, addrSel=0 (PC), aluOp=0 (add), aluSrcA=2 (PC), aluSrcB=2 (constant one), pcSrc=0 (ALU) and pcWrite=1, with every other strobe at 0. It is followed by one decode cycle in which all strobes are 0.
- R3: memRead and memWrite are never 1 in the same cycle. Data accesses drive addrSel=1 (address register): a store cycle has memWrite=1 and a load cycle has memRead=1.
- R4: pcWrite and regWrite are never 1 in the same cycle.
- R5: Class 0 (ALU) runs an execute cycle with aluOp=2 (opcode-directed) and aluSrcA=0, then a write-back cycle with regWrite=1 and wbSrc=0. aluSrcB in the execute cycle is 0 (register) when extBit=0 and 1 (immediate) when extBit=1. With extBit=1, a second-word fetch cycle with the same strobes as a fetch cycle comes before execute.
- R6: Class 1 (load) and class 2 (store) run an address cycle with aluOp=0, aluSrcA=0, and aluSrcB=1 if extBit=1 or 3 (zero) if extBit=0. A second-word fetch cycle comes before it when extBit=1. Store then runs one write cycle. Load runs one read cycle, then a cycle with regWrite=1 and wbSrc=1 (memory).
- R7: Class 4 (jump and link) runs a link cycle with regWrite=1 and wbSrc=2 (PC), then a jump cycle. Class 3 (register jump) goes straight to the jump cycle. The jump cycle drives pcWrite=1, pcSrc=0, aluOp=0, aluSrcA=0, and aluSrcB=1 if extBit=1 or 3 if extBit=0. With extBit=1, both classes fetch a second word first.
- R8: Class 5 (branch) runs a compare cycle with aluOp=1 (subtract), aluSrcA=0 and aluSrcB=0. If condTrue=1 in that cycle, a taken cycle follows with pcSrc=1 (branch field) and pcWrite=1. Otherwise an idle cycle with all strobes 0 follows. extBit has no effect on this class.
- R9: At the end-check cycle, if intEnable=1 and intReq=1, the next cycle drives iraWrite=1, intEnClear=1, pcSrc=3 (service vector) and pcWrite=1, and a fetch cycle follows it.
- R10: The end-check cycle has all strobes at 0. If intEnable=0 or intReq=0, a fetch cycle follows it directly.
- R11: Class 6 (return from interrupt) runs one cycle after decode with pcSrc=2 (return register), pcWrite=1 and intEnSet=1, then goes to the end-check cycle.
- R12: Class 7 (reserved) goes from decode straight to the end-check cycle and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrClass | input | 3 | Decoded instruction class (codes 0 to 7) |
| extBit | input | 1 | Instruction carries a second word |
| condTrue | input | 1 | Branch condition from the ALU compare |
| intEnable | input | 1 | Interrupt-enable status flag |
| intReq | input | 1 | Interrupt request |
| addrSel | output | 1 | Memory address source: 0 PC, 1 address register |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| aluOp | output | 2 | 0 add, 1 subtract, 2 opcode-directed |
| aluSrcA | output | 2 | Operand A: 0 register, 2 PC |
| aluSrcB | output | 2 | Operand B: 0 register, 1 immediate, 2 one, 3 zero |
| pcSrc | output | 2 | 0 ALU, 1 branch field, 2 return register, 3 service vector |
| pcWrite | output | 1 | PC write enable |
| regWrite | output | 1 | Register file write enable |
| wbSrc | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC |
| iraWrite | output | 1 | Save the PC into the interrupt return register |
| intEnClear | output | 1 | Clear the interrupt-enable flag |
| intEnSet | output | 1 | Set the interrupt-enable flag |

## Verification
The block has no module parameters: the state width, class width and select widths are fixed in the package. The bench instantiates it as it stands, so all eight class codes and all sixteen state codes can be reached. Every class runs with extBit both clear and set, and the branch class runs with the condition both true and false. The end-check cycle is run with each combination of enable flag and request, so the service-vector entry and the direct return to fetch are both exercised.

// File: rtl/seqPkg.sv
package seqPkg;

  localparam int unsigned STATE_W = 4;
  localparam int unsigned CLASS_W = 3;
  localparam int unsigned SEL_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_EXEC   = 4'd2,
    S_WBALU  = 4'd3,
    S_IMM    = 4'd4,
    S_MEMWR  = 4'd5,
    S_MEMRD  = 4'd6,
    S_WBMEM  = 4'd7,
    S_ADDR   = 4'd8,
    S_INTGO  = 4'd9,
    S_CMP    = 4'd10,
    S_BRJMP  = 4'd11,
    S_JREG   = 4'd12,
    S_LINK   = 4'd13,
    S_BRSKIP = 4'd14,
    S_ENDCHK = 4'd15
  } seqState_t;

  typedef enum logic [CLASS_W-1:0] {
    C_ALU    = 3'd0,
    C_LOAD   = 3'd1,
    C_STORE  = 3'd2,
    C_JMP    = 3'd3,
    C_JLINK  = 3'd4,
    C_BRANCH = 3'd5,
    C_RETI   = 3'd6,
    C_RSVD   = 3'd7
  } instrClass_t;

  typedef enum logic [SEL_W-1:0] {
    ALU_ADD  = 2'd0,
    ALU_SUB  = 2'd1,
    ALU_FUNC = 2'd2
  } aluOp_t;

  localparam logic [SEL_W-1:0] SRCA_REG = 2'd0;
  localparam logic [SEL_W-1:0] SRCA_PC  = 2'd2;
  localparam logic [SEL_W-1:0] SRCB_REG = 2'd0;
  localparam logic [SEL_W-1:0] SRCB_IMM = 2'd1;
  localparam logic [SEL_W-1:0] SRCB_ONE = 2'd2;
  localparam logic [SEL_W-1:0] SRCB_ZERO = 2'd3;
  localparam logic [SEL_W-1:0] PCS_ALU  = 2'd0;
  localparam logic [SEL_W-1:0] PCS_BR   = 2'd1;
  localparam logic [SEL_W-1:0] PCS_IRA  = 2'd2;
  localparam logic [SEL_W-1:0] PCS_VEC  = 2'd3;
  localparam logic [SEL_W-1:0] WB_ALU   = 2'd0;
  localparam logic [SEL_W-1:0] WB_MEM   = 2'd1;
  localparam logic [SEL_W-1:0] WB_PC    = 2'd2;

  typedef struct packed {
    logic             addrSel;
    logic             memRead;
    logic             memWrite;
    aluOp_t           aluOp;
    logic [SEL_W-1:0] aluSrcA;
    logic [SEL_W-1:0] aluSrcB;
    logic [SEL_W-1:0] pcSrc;
    logic             pcWrite;
    logic             regWrite;
    logic [SEL_W-1:0] wbSrc;
    logic             iraWrite;
    logic             intEnClear;
    logic             intEnSet;
  } strobes_t;

endpackage

// File: rtl/seqNext.sv
module seqNext
  import seqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [CLASS_W-1:0] instrClass,
  input  logic               extBit,
  input  logic               condTrue,
  input  logic               intEnable,
  input  logic               intReq,
  output seqState_t          curState
);

  seqState_t   nextState;
  instrClass_t cls;

  assign cls = instrClass_t'(instrClass);

  always_comb begin
    nextState = S_FETCH;
    unique case (curState)
      S_FETCH:  nextState = S_DECODE;
      S_DECODE: begin
        case (cls)
          C_ALU:            nextState = extBit ? S_IMM : S_EXEC;
          C_LOAD, C_STORE:  nextState = extBit ? S_IMM : S_ADDR;
          C_JMP:            nextState = extBit ? S_IMM : S_JREG;
          C_JLINK:          nextState = extBit ? S_IMM : S_LINK;
          C_BRANCH:         nextState = S_CMP;
          C_RETI:           nextState = S_JREG;
          default:          nextState = S_ENDCHK;
        endcase
      end
      S_IMM: begin
        case (cls)
          C_ALU:           nextState = S_EXEC;
          C_LOAD, C_STORE: nextState = S_ADDR;
          C_JMP:           nextState = S_JREG;
          C_JLINK:         nextState = S_LINK;
          default:         nextState = S_ENDCHK;
        endcase
      end
      S_EXEC:   nextState = S_WBALU;
      S_WBALU:  nextState = S_ENDCHK;
      S_ADDR:   nextState = (cls == C_STORE) ? S_MEMWR : S_MEMRD;
      S_MEMWR:  nextState = S_ENDCHK;
      S_MEMRD:  nextState = S_WBMEM;
      S_WBMEM:  nextState = S_ENDCHK;
      S_LINK:   nextState = S_JREG;
      S_JREG:   nextState = S_ENDCHK;
      S_CMP:    nextState = condTrue ? S_BRJMP : S_BRSKIP;
      S_BRJMP:  nextState = S_ENDCHK;
      S_BRSKIP: nextState = S_ENDCHK;
      S_ENDCHK: nextState = (intEnable && intReq) ? S_INTGO : S_FETCH;
      S_INTGO:  nextState = S_FETCH;
      default:  nextState = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= S_FETCH;
    else       curState <= nextState;
  end

endmodule

// File: rtl/seqDecode.sv
module seqDecode
  import seqPkg::*;
(
  input  seqState_t          curState,
  input  logic [CLASS_W-1:0] instrClass,
  input  logic               extBit,
  output strobes_t           strb
);

  logic [SEL_W-1:0] secondSrc;

  assign secondSrc = extBit ? SRCB_IMM : SRCB_ZERO;

  always_comb begin
    strb = '0;
    unique case (curState)
      S_FETCH, S_IMM: begin
        strb.memRead = 1'b1;
        strb.aluOp   = ALU_ADD;
        strb.aluSrcA = SRCA_PC;
        strb.aluSrcB = SRCB_ONE;
        strb.pcSrc   = PCS_ALU;
        strb.pcWrite = 1'b1;
      end
      S_EXEC: begin
        strb.aluOp   = ALU_FUNC;
        strb.aluSrcA = SRCA_REG;
        strb.aluSrcB = extBit ? SRCB_IMM : SRCB_REG;
      end
      S_WBALU: begin
        strb.regWrite = 1'b1;
        strb.wbSrc    = WB_ALU;
      end
      S_ADDR: begin
        strb.aluOp   = ALU_ADD;
        strb.aluSrcA = SRCA_REG;
        strb.aluSrcB = secondSrc;
      end
      S_MEMWR: begin
        strb.addrSel  = 1'b1;
        strb.memWrite = 1'b1;
      end
      S_MEMRD: begin
        strb.addrSel = 1'b1;
        strb.memRead = 1'b1;
      end
      S_WBMEM: begin
        strb.regWrite = 1'b1;
        strb.wbSrc    = WB_MEM;
      end
      S_LINK: begin
        strb.regWrite = 1'b1;
        strb.wbSrc    = WB_PC;
      end
      S_JREG: begin
        strb.pcWrite = 1'b1;
        if (instrClass_t'(instrClass) == C_RETI) begin
          strb.pcSrc    = PCS_IRA;
          strb.intEnSet = 1'b1;
        end else begin
          strb.aluOp   = ALU_ADD;
          strb.aluSrcA = SRCA_REG;
          strb.aluSrcB = secondSrc;
          strb.pcSrc   = PCS_ALU;
        end
      end
      S_CMP: begin
        strb.aluOp   = ALU_SUB;
        strb.aluSrcA = SRCA_REG;
        strb.aluSrcB = SRCB_REG;
      end
      S_BRJMP: begin
        strb.pcSrc   = PCS_BR;
        strb.pcWrite = 1'b1;
      end
      S_INTGO: begin
        strb.iraWrite   = 1'b1;
        strb.intEnClear = 1'b1;
        strb.pcSrc      = PCS_VEC;
        strb.pcWrite    = 1'b1;
      end
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [CLASS_W-1:0] instrClass,
  input  logic               extBit,
  input  logic               condTrue,
  input  logic               intEnable,
  input  logic               intReq,
  output logic               addrSel,
  output logic               memRead,
  output logic               memWrite,
  output logic [SEL_W-1:0]   aluOp,
  output logic [SEL_W-1:0]   aluSrcA,
  output logic [SEL_W-1:0]   aluSrcB,
  output logic [SEL_W-1:0]   pcSrc,
  output logic               pcWrite,
  output logic               regWrite,
  output logic [SEL_W-1:0]   wbSrc,
  output logic               iraWrite,
  output logic               intEnClear,
  output logic               intEnSet
);

  seqState_t curState;
  strobes_t  rawStrb;
  strobes_t  outStrb;

  seqNext uNext (
    .clk(clk), .rstN(rstN), .instrClass(instrClass), .extBit(extBit),
    .condTrue(condTrue), .intEnable(intEnable), .intReq(intReq),
    .curState(curState)
  );

  seqDecode uDecode (
    .curState(curState), .instrClass(instrClass), .extBit(extBit),
    .strb(rawStrb)
  );

  // Hold every strobe low while reset is asserted.
  assign outStrb = rstN ? rawStrb : '0;

  assign addrSel    = outStrb.addrSel;
  assign memRead    = outStrb.memRead;
  assign memWrite   = outStrb.memWrite;
  assign aluOp      = outStrb.aluOp;
  assign aluSrcA    = outStrb.aluSrcA;
  assign aluSrcB    = outStrb.aluSrcB;
  assign pcSrc      = outStrb.pcSrc;
  assign pcWrite    = outStrb.pcWrite;
  assign regWrite   = outStrb.regWrite;
  assign wbSrc      = outStrb.wbSrc;
  assign iraWrite   = outStrb.iraWrite;
  assign intEnClear = outStrb.intEnClear;
  assign intEnSet   = outStrb.intEnSet;

endmodule

// File: rtl/seqCtrlChk.sv
module seqCtrlChk (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] curState,
  input logic       intEnable,
  input logic       intReq,
  input logic       addrSel,
  input logic       memRead,
  input logic       memWrite,
  input logic [1:0] pcSrc,
  input logic       pcWrite,
  input logic       regWrite,
  input logic [1:0] wbSrc,
  input logic       iraWrite,
  input logic       intEnClear
);

  a_r3_rd_wr_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));

  a_r4_single_writer: assert property (@(posedge clk) disable iff (!rstN)
    !(pcWrite && regWrite));

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 4'd0) |=> (curState == 4'd1));

  a_r6_load_writeback: assert property (@(posedge clk) disable iff (!rstN)
    (memRead && addrSel) |=> (regWrite && wbSrc == 2'd1));

  a_r7_link_then_jump: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && wbSrc == 2'd2) |=> (pcWrite && pcSrc == 2'd0));

  a_r9_irq_entry: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 4'd15 && intEnable && intReq)
      |=> (iraWrite && intEnClear && pcWrite && pcSrc == 2'd3));

  a_r10_irq_skip: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 4'd15 && !(intEnable && intReq))
      |=> (memRead && pcWrite && !addrSel));

endmodule

bind seqCtrl seqCtrlChk uChk (
  .clk(clk), .rstN(rstN), .curState(curState), .intEnable(intEnable),
  .intReq(intReq), .addrSel(addrSel), .memRead(memRead), .memWrite(memWrite),
  .pcSrc(pcSrc), .pcWrite(pcWrite), .regWrite(regWrite), .wbSrc(wbSrc),
  .iraWrite(iraWrite), .intEnClear(intEnClear)
);

// File: tb/tb_seqCtrl.sv
module tb_seqCtrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] instrClass = 3'd0;
  logic       extBit = 1'b0;
  logic       condTrue = 1'b0;
  logic       intEnable = 1'b1;
  logic       intReq = 1'b1;
  logic       addrSel, memRead, memWrite, pcWrite, regWrite;
  logic       iraWrite, intEnClear, intEnSet;
  logic [1:0] aluOp, aluSrcA, aluSrcB, pcSrc, wbSrc;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [17:0] v;
    int          st;
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t cur;

  always #10 clk = ~clk;

  seqCtrl dut (
    .clk(clk), .rstN(rstN), .instrClass(instrClass), .extBit(extBit),
    .condTrue(condTrue), .intEnable(intEnable), .intReq(intReq),
    .addrSel(addrSel), .memRead(memRead), .memWrite(memWrite),
    .aluOp(aluOp), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .pcSrc(pcSrc),
    .pcWrite(pcWrite), .regWrite(regWrite), .wbSrc(wbSrc),
    .iraWrite(iraWrite), .intEnClear(intEnClear), .intEnSet(intEnSet)
  );

  function automatic logic [17:0] observed();
    return {addrSel, memRead, memWrite, aluOp, aluSrcA, aluSrcB, pcSrc,
            pcWrite, regWrite, wbSrc, iraWrite, intEnClear, intEnSet};
  endfunction

  // Expected strobes per cycle kind, taken from the requirement text.
  function automatic logic [17:0] expOf(int st, int cls, bit ext);
    logic a = 0, rd = 0, wr = 0, pw = 0, rw = 0, ira = 0, iec = 0, ies = 0;
    logic [1:0] op = 0, sa = 0, sb = 0, ps = 0, wb = 0;
    case (st)
      0, 4: begin rd = 1; sa = 2; sb = 2; pw = 1; end          // R2
      2:    begin op = 2; sb = ext ? 2'd1 : 2'd0; end           // R5
      3:    rw = 1;                                             // R5
      5:    begin a = 1; wr = 1; end                            // R6
      6:    begin a = 1; rd = 1; end                            // R6
      7:    begin rw = 1; wb = 1; end                           // R6
      8:    sb = ext ? 2'd1 : 2'd3;                             // R6
      9:    begin ira = 1; iec = 1; ps = 3; pw = 1; end         // R9
      10:   op = 1;                                             // R8
      11:   begin ps = 1; pw = 1; end                           // R8
      12:   if (cls == 6) begin ps = 2; pw = 1; ies = 1; end    // R11
            else begin sb = ext ? 2'd1 : 2'd3; pw = 1; end      // R7
      13:   begin rw = 1; wb = 2; end                           // R7
      default: ;
    endcase
    return {a, rd, wr, op, sa, sb, ps, pw, rw, wb, ira, iec, ies};
  endfunction

  task automatic checkVal(string req, logic [17:0] got, logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle, away from the clock edge.
  always @(negedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      cur = expQ.pop_front();
      checks++;
      if (observed() !== cur.v) begin
        errors++;
        $display("FAIL %s cycle kind %0d: got %h expected %h",
                 cur.req, cur.st, observed(), cur.v);
      end
    end
  end

  // Driver: sets inputs at the fetch cycle and queues the expected cycles.
  task automatic runInstr(int cls, bit ext, bit cond, bit ie, bit irq, string req);
    int path[$];
    @(negedge clk);
    instrClass = cls[2:0]; extBit = ext; condTrue = cond;
    intEnable = ie; intReq = irq;
    path.push_back(0); path.push_back(1);
    if (ext && cls <= 4) path.push_back(4);
    case (cls)
      0: begin path.push_back(2); path.push_back(3); end
      1: begin path.push_back(8); path.push_back(6); path.push_back(7); end
      2: begin path.push_back(8); path.push_back(5); end
      3: path.push_back(12);
      4: begin path.push_back(13); path.push_back(12); end
      5: begin path.push_back(10); path.push_back(cond ? 11 : 14); end
      6: path.push_back(12);
      default: ;
    endcase
    path.push_back(15);
    if (ie && irq) path.push_back(9);
    foreach (path[i]) begin
      expItem_t it;
      it.v = expOf(path[i], cls, ext);
      it.st = path[i];
      it.req = req;
      expQ.push_back(it);
    end
    do begin @(negedge clk); #3; end while (expQ.size() != 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2 checkVal("R1 reset strobes", observed(), 18'h0);
    @(posedge clk); #1 rstN = 1'b1;
    runInstr(0, 0, 0, 0, 0, "R1 R2 R5 alu reg");
    runInstr(0, 1, 0, 0, 0, "R5 alu imm");
    runInstr(1, 0, 0, 0, 0, "R6 r3_load");
    runInstr(1, 1, 0, 0, 0, "R6 load disp");
    runInstr(2, 0, 0, 0, 0, "R6 r3_store");
    runInstr(2, 1, 0, 0, 0, "R6 store disp");
    runInstr(3, 0, 0, 0, 0, "R7 jump reg");
    runInstr(3, 1, 0, 0, 0, "R7 jump disp");
    runInstr(4, 0, 0, 0, 0, "R7 r4_link");
    runInstr(4, 1, 0, 0, 0, "R7 link disp");
    runInstr(5, 0, 1, 0, 0, "R8 branch taken");
    runInstr(5, 0, 0, 0, 0, "R8 branch not taken");
    runInstr(5, 1, 1, 0, 0, "R8 branch ext ignored");
    runInstr(5, 1, 0, 0, 0, "R8 branch ext ignored nt");
    runInstr(0, 0, 0, 1, 1, "R9 irq taken");
    runInstr(1, 0, 0, 1, 1, "R9 irq after load");
    runInstr(6, 0, 0, 0, 0, "R11 reti");
    runInstr(6, 1, 0, 0, 1, "R11 R10 reti ext irq masked");
    runInstr(0, 0, 0, 0, 1, "R10 irq disabled");
    runInstr(2, 0, 0, 1, 0, "R10 no request");
    runInstr(7, 0, 0, 1, 0, "R12 reserved");
    runInstr(7, 1, 0, 0, 0, "R12 reserved ext");
    runInstr(0, 0, 0, 0, 0, "R2 final fetch");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule